// File: doc/BRIEF.md
# OSD Serial Packet Address Decoder

This block sits between a serial slave receiver and the display memory of an on-screen display controller. The receiver has already consumed the device address byte (0x7A) and delivers the remaining payload one byte at a time with a valid strobe, plus single-cycle strobes for the bus start and stop events. The decoder sorts each byte into one of three kinds: row address, column address or display information. It tracks a row and column pointer and issues one write command for each information byte into a 16-row by 32-column memory. In that memory, rows 0-14 and columns 0-29 hold character codes, columns 30-31 of each row hold row controls, and row 15 holds the window and frame registers.

The host can use three packet formats. In format (a), every info byte is preceded by its own row and column. In format (b), one row byte is followed by repeated column and info pairs. In format (c), a single row and column are followed by an unbroken stream of info bytes written at consecutive locations. Format (c) is selected by a flag in the column byte. Once selected, it holds until the transfer ends, so every later byte is data, whatever its top bit.

Control is a five-state machine:
- `ST_ROW` waits for a row address.
- `ST_COL` waits for a column address.
- `ST_INFO` takes one info byte.
- `ST_NEXT` follows an info byte in formats (a) and (b), and bit 7 of the next byte picks a new row or a new column.
- `ST_BURST` streams format (c) data.

The transitions are:
- `ST_ROW`→`ST_COL` on a row byte.
- `ST_COL`→`ST_COL` on a row byte.
- `ST_COL`→`ST_INFO` on a column byte with the burst flag clear.
- `ST_COL`→`ST_BURST` on a column byte with the burst flag set.
- `ST_INFO`→`ST_NEXT` on any byte.
- `ST_NEXT`→`ST_COL` on a row byte.
- `ST_NEXT`→`ST_INFO` or `ST_BURST` on a column byte, chosen as from `ST_COL`.
- `ST_BURST`→`ST_BURST` on any byte.
- Any state→`ST_ROW` on a start or stop event.

Top module: `osd_pkt_decoder`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset is released, `wr_en` is 0 and the decoder waits for a row address.
- R2: When a row address is expected, a byte with bit 7 = 1 loads the row pointer from bits 3-0, and bits 6-4 are ignored. A byte with bit 7 = 0 in that state is discarded: it produces no write and the decoder keeps waiting for a row.
- R3: When a column address is expected, a byte with bit 7 = 0 loads the column pointer from bits 4-0, and bit 5 is ignored. Bit 6 = 1 selects the burst format and bit 6 = 0 selects a single info byte.
- R4: An info byte produces exactly one write at the current row and column, carrying that byte. The write appears on `wr_en`, `wr_row`, `wr_col` and `wr_data` in the cycle after the byte's valid cycle, and `wr_en` pulses for one cycle only.
- R5: After an info byte in format (a) or (b), a following byte with bit 7 = 0 is a new column in the same row (format b), and a byte with bit 7 = 1 is a new row (format a).
- R6: In burst mode, each byte is written at the current location and the column then advances by one.
- R7: In burst mode, after column 31 the column wraps to 0 and the row advances by one. Row 15 wraps to row 0.
- R8: Burst mode is sticky: bytes with bit 7 = 1 are written as data, not taken as row addresses, until a start or stop event.
- R9: A start or stop event returns the decoder to waiting for a row and leaves burst mode. A byte presented in the same cycle as an event is discarded.
- R10: When a column is expected, a byte with bit 7 = 1 replaces the row pointer and the decoder keeps waiting for a column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_vld | input | 1 | Received byte is valid this cycle |
| byte_data | input | 8 | Received payload byte |
| start_evt | input | 1 | Bus start event strobe |
| stop_evt | input | 1 | Bus stop event strobe |
| wr_en | output | 1 | Display memory write strobe |
| wr_row | output | ROW_W (4) | Write row address |
| wr_col | output | COL_W (5) | Write column address |
| wr_data | output | DATA_W (8) | Write data |

## Verification
The bench builds the decoder with its default widths: a 4-bit row, a 5-bit column and 8-bit data. This puts the full 16 × 32 map within reach. A burst started at row 15, column 30 crosses both the column wrap and the row wrap in four bytes. The same widths let the ignored bits of the row and column bytes be set and shown to have no effect on the write address.

// File: rtl/osd_dec_pkg.sv
package osd_dec_pkg;

    // Bit 7 of an address byte selects row (1) or column (0)
    localparam int KIND_BIT  = 7;
    // Bit 6 of a column byte selects the burst format
    localparam int BURST_BIT = 6;

    typedef enum logic [2:0] {
        ST_ROW   = 3'd0,
        ST_COL   = 3'd1,
        ST_INFO  = 3'd2,
        ST_NEXT  = 3'd3,
        ST_BURST = 3'd4
    } dec_state_e;

endpackage

// File: rtl/osd_ptr.sv
module osd_ptr #(
    parameter int ROW_W  = 4,
    parameter int COL_W  = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_row,
    input  logic              ld_col,
    input  logic              adv,
    input  logic [DATA_W-1:0] din,
    output logic [ROW_W-1:0]  row,
    output logic [COL_W-1:0]  col
);

    localparam logic [COL_W-1:0] COL_LAST = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row <= '0;
            col <= '0;
        end else begin
            if (ld_row) begin
                row <= din[ROW_W-1:0];
            end
            if (ld_col) begin
                col <= din[COL_W-1:0];
            end
            if (adv) begin
                if (col == COL_LAST) begin
                    col <= '0;
                    row <= row + 1'b1;
                end else begin
                    col <= col + 1'b1;
                end
            end
        end
    end

    AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !ld_col && !ld_row && col != COL_LAST) |=> (col == $past(col) + 1'b1) && (row == $past(row))); // R6

    AST_COL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !ld_col && !ld_row && col == COL_LAST) |=> (col == '0) && (row == $past(row) + 1'b1)); // R7

endmodule

// File: rtl/osd_wr_port.sv
module osd_wr_port #(
    parameter int ROW_W  = 4,
    parameter int COL_W  = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [ROW_W-1:0]  row,
    input  logic [COL_W-1:0]  col,
    input  logic [DATA_W-1:0] data,
    output logic              wr_en,
    output logic [ROW_W-1:0]  wr_row,
    output logic [COL_W-1:0]  wr_col,
    output logic [DATA_W-1:0] wr_data
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_row  <= '0;
            wr_col  <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= wr_req;
            if (wr_req) begin
                wr_row  <= row;
                wr_col  <= col;
                wr_data <= data;
            end
        end
    end

    AST_WR_PULSE_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> wr_en && (wr_data == $past(data))); // R4

endmodule

// File: rtl/osd_pkt_decoder.sv
module osd_pkt_decoder
    import osd_dec_pkg::*;
#(
    parameter int ROW_W  = 4,
    parameter int COL_W  = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              start_evt,
    input  logic              stop_evt,
    output logic              wr_en,
    output logic [ROW_W-1:0]  wr_row,
    output logic [COL_W-1:0]  wr_col,
    output logic [DATA_W-1:0] wr_data
);

    dec_state_e       st, st_nxt;
    logic             evt;
    logic             is_row, is_burst;
    logic             ld_row, ld_col, wr_req, adv;
    logic [ROW_W-1:0] cur_row;
    logic [COL_W-1:0] cur_col;

    assign evt      = start_evt | stop_evt;
    assign is_row   = byte_data[KIND_BIT];
    assign is_burst = byte_data[BURST_BIT];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_ROW;
        end else begin
            st <= st_nxt;
        end
    end

    // Next state
    always_comb begin
        st_nxt = st;
        if (evt) begin
            st_nxt = ST_ROW;
        end else if (byte_vld) begin
            unique case (st)
                ST_ROW:   if (is_row) st_nxt = ST_COL;
                ST_COL,
                ST_NEXT:  begin
                    if (is_row)        st_nxt = ST_COL;
                    else if (is_burst) st_nxt = ST_BURST;
                    else               st_nxt = ST_INFO;
                end
                ST_INFO:  st_nxt = ST_NEXT;
                ST_BURST: st_nxt = ST_BURST;
                default:  st_nxt = ST_ROW;
            endcase
        end
    end

    // Control outputs
    always_comb begin
        ld_row = 1'b0;
        ld_col = 1'b0;
        wr_req = 1'b0;
        adv    = 1'b0;
        if (byte_vld && !evt) begin
            unique case (st)
                ST_ROW:   ld_row = is_row;
                ST_COL,
                ST_NEXT:  begin
                    ld_row = is_row;
                    ld_col = !is_row;
                end
                ST_INFO:  wr_req = 1'b1;
                ST_BURST: begin
                    wr_req = 1'b1;
                    adv    = 1'b1;
                end
                default:  ;
            endcase
        end
    end

    osd_ptr #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_row (ld_row),
        .ld_col (ld_col),
        .adv    (adv),
        .din    (byte_data),
        .row    (cur_row),
        .col    (cur_col)
    );

    osd_wr_port #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_wr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_req  (wr_req),
        .row     (cur_row),
        .col     (cur_col),
        .data    (byte_data),
        .wr_en   (wr_en),
        .wr_row  (wr_row),
        .wr_col  (wr_col),
        .wr_data (wr_data)
    );

    AST_EVT_DROPS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> !wr_en); // R9

    AST_WR_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(byte_vld)); // R4

    AST_BURST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BURST && !evt) |=> (st == ST_BURST)); // R8

    AST_ROW_WAIT_SKIPS_COL: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ROW && byte_vld && !is_row && !evt) |=> (!wr_en && st == ST_ROW)); // R2

endmodule

// File: tb/osd_pkt_decoder_tb.sv
module osd_pkt_decoder_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_data = '0;
    logic       start_evt = 1'b0;
    logic       stop_evt = 1'b0;
    logic       wr_en;
    logic [3:0] wr_row;
    logic [4:0] wr_col;
    logic [7:0] wr_data;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    osd_pkt_decoder u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_vld  (byte_vld),
        .byte_data (byte_data),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .wr_en     (wr_en),
        .wr_row    (wr_row),
        .wr_col    (wr_col),
        .wr_data   (wr_data)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Send one byte, then check the write port one cycle later
    task automatic put(input logic [7:0] d, input bit ew,
                       input int er, input int ec, input string req);
        @(negedge clk);
        byte_vld  = 1'b1;
        byte_data = d;
        @(negedge clk);
        byte_vld  = 1'b0;
        check({req, " wr_en"}, int'(wr_en), int'(ew));
        if (ew) begin
            check({req, " row"},  int'(wr_row),  er);
            check({req, " col"},  int'(wr_col),  ec);
            check({req, " data"}, int'(wr_data), int'(d));
        end
    endtask

    task automatic pulse_evt(input bit is_start, input bit with_byte, input logic [7:0] d);
        @(negedge clk);
        start_evt = is_start;
        stop_evt  = !is_start;
        byte_vld  = with_byte;
        byte_data = d;
        @(negedge clk);
        start_evt = 1'b0;
        stop_evt  = 1'b0;
        byte_vld  = 1'b0;
        check("R9 evt drops byte", int'(wr_en), 0);
    endtask

    task automatic t_reset();
        check("R1 reset wr_en", int'(wr_en), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset wr_en", int'(wr_en), 0);
        put(8'h45, 1'b0, 0, 0, "R2 col byte ignored in row wait");
        put(8'h82, 1'b0, 0, 0, "R2 row load");
        put(8'h05, 1'b0, 0, 0, "R3 col load");
        put(8'h33, 1'b1, 2, 5, "R2 R4 still waited for row");
    endtask

    task automatic t_fmt_a();
        pulse_evt(1'b1, 1'b0, 8'h00);
        put(8'hF3, 1'b0, 0, 0, "R2 row 3 upper bits");
        put(8'h2A, 1'b0, 0, 0, "R3 col 10 bit5 set");
        put(8'h55, 1'b1, 3, 10, "R4 format a first");
        put(8'h87, 1'b0, 0, 0, "R5 new row");
        put(8'h01, 1'b0, 0, 0, "R5 new col");
        put(8'h99, 1'b1, 7, 1, "R5 format a second");
    endtask

    task automatic t_fmt_b();
        pulse_evt(1'b0, 1'b0, 8'h00);
        put(8'h84, 1'b0, 0, 0, "R5 b row");
        put(8'h02, 1'b0, 0, 0, "R5 b col");
        put(8'h11, 1'b1, 4, 2, "R5 b first");
        put(8'h1E, 1'b0, 0, 0, "R5 b col 30");
        put(8'h22, 1'b1, 4, 30, "R5 b second same row");
        put(8'h23, 1'b0, 0, 0, "R5 b next byte is address");
    endtask

    task automatic t_row_in_col();
        pulse_evt(1'b1, 1'b0, 8'h00);
        put(8'h85, 1'b0, 0, 0, "R10 first row");
        put(8'h86, 1'b0, 0, 0, "R10 row replaced");
        put(8'h03, 1'b0, 0, 0, "R10 col");
        put(8'h44, 1'b1, 6, 3, "R10 write at replaced row");
    endtask

    task automatic t_burst();
        pulse_evt(1'b1, 1'b0, 8'h00);
        put(8'h81, 1'b0, 0, 0, "R6 burst row");
        put(8'h44, 1'b0, 0, 0, "R3 burst col 4");
        put(8'hA0, 1'b1, 1, 4, "R6 R8 burst 0");
        put(8'hB1, 1'b1, 1, 5, "R6 R8 burst 1");
        put(8'h8C, 1'b1, 1, 6, "R6 R8 burst 2");
        put(8'h07, 1'b1, 1, 7, "R6 burst 3");
    endtask

    task automatic t_wrap();
        pulse_evt(1'b1, 1'b0, 8'h00);
        put(8'h8F, 1'b0, 0, 0, "R7 row 15");
        put(8'h5E, 1'b0, 0, 0, "R7 col 30 burst");
        put(8'h10, 1'b1, 15, 30, "R7 wrap 0");
        put(8'h11, 1'b1, 15, 31, "R7 wrap 1");
        put(8'h12, 1'b1, 0, 0, "R7 wrap 2");
        put(8'h13, 1'b1, 0, 1, "R7 wrap 3");
    endtask

    task automatic t_evt();
        pulse_evt(1'b0, 1'b1, 8'h66);
        put(8'h01, 1'b0, 0, 0, "R9 burst left, col byte ignored");
        put(8'h82, 1'b0, 0, 0, "R9 row");
        put(8'h40, 1'b0, 0, 0, "R9 col burst");
        put(8'hC5, 1'b1, 2, 0, "R9 burst again");
        pulse_evt(1'b1, 1'b1, 8'h77);
        put(8'h93, 1'b0, 0, 0, "R9 row after start");
        put(8'h08, 1'b0, 0, 0, "R9 col");
        put(8'h5A, 1'b1, 3, 8, "R9 single write");
        put(8'h09, 1'b0, 0, 0, "R9 not burst");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_fmt_a();
        t_fmt_b();
        t_row_in_col();
        t_burst();
        t_wrap();
        t_evt();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule